// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit free-running timer and a watchdog timeout counter. The two share one power-of-two prescaler. A single write-only configuration byte sets up both halves. It picks the timer's count source, which is either a per-instruction tick enable or an asynchronous external clock pin counted on a chosen edge. It also decides which half owns the prescaler and sets the division ratio. The configuration byte is loaded by a one-cycle write strobe. It cannot be read back, so every setting is observed through the timer, flag and timeout behaviour.

The half that does not own the prescaler runs undivided. When the watchdog owns it, each rate code divides by half as much as the same code would divide the timer, so the lowest code passes the watchdog base tick straight through. The watchdog counts its post-prescaler ticks. After `WDT_LIMIT` of them it emits a one-cycle timeout pulse and starts over, unless a clear arrives first. All pins are plain control and status signals. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_wdt_shared`

## Requirements
- R1: After reset the configuration byte reads as all ones. Both the wake disable and pull-up disable outputs are high, the external pin is selected (the force-input output is high), and instruction ticks do not move the timer. The timer reads 0, the overflow flag is low and the timeout is low.
- R2: A write strobe loads the configuration byte for use from the next clock onward. The bit layout is: bit 7 wake disable, bit 6 pull-up disable, bit 5 clock select, bit 4 edge select, bit 3 prescaler owner, bits 2:0 rate code.
- R3: Clock select 0 counts instruction ticks and ignores the external pin. Clock select 1 counts external pin edges and ignores instruction ticks. The force-input output equals clock select.
- R4: The external pin passes through a two-flop synchroniser. Edge select 0 counts low-to-high transitions and edge select 1 counts high-to-low transitions. A transition reaches the count within four clocks.
- R5: With prescaler owner 0 (timer), rate code k advances the timer once per 2^(k+1) source events.
- R6: With prescaler owner 1 (watchdog), rate code k advances the watchdog once per 2^k base ticks, so code 0 passes ticks undivided. Meanwhile the timer advances on every source event.
- R7: The timer wraps from 0xFF to 0x00 and sets a sticky overflow flag. The flag clear input drops it, but a wrap in the same cycle as a clear leaves it set.
- R8: A timer write with prescaler owner 0 empties the prescaler. With owner 1, a timer write leaves the prescaler untouched.
- R9: The timeout output pulses high for exactly one cycle, in the cycle after the WDT_LIMIT-th post-prescaler watchdog tick since the last clear or timeout. A watchdog clear restarts that count and empties the prescaler.
- R10: A timer write loads the written value and takes priority over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_wdata_i | input | 8 | Configuration byte value |
| insn_tick_i | input | 1 | Instruction-cycle tick enable |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | 8 | Timer write value |
| ovf_clr_i | input | 1 | Overflow flag clear |
| wdt_tick_i | input | 1 | Watchdog base tick enable |
| wdt_clr_i | input | 1 | Watchdog clear |
| tmr_count_o | output | 8 | Timer count |
| tmr_ovf_o | output | 1 | Sticky timer overflow flag |
| wdt_timeout_o | output | 1 | One-cycle watchdog timeout pulse |
| ext_force_in_o | output | 1 | External pin must be an input |
| wake_dis_o | output | 1 | Wake-on-change disable setting |
| pullup_dis_o | output | 1 | Weak pull-up disable setting |

## Verification
The bench builds the block with the default 8-bit timer and prescaler and with WDT_LIMIT set to 4. A timeout then arrives after only four post-prescaler ticks, so undivided, divided-by-two and cleared-midway watchdog runs each fit in a handful of cycles. The full 8-bit prescaler still gives every timer rate code its real ratio. Keeping the timer at 8 bits leaves the 0xFF-to-0x00 wrap and the write priorities reachable by direct loads.

// File: rtl/twd_pkg.sv
package twd_pkg;
  parameter int RATE_W = 3;

  typedef struct packed {
    logic              wake_dis;
    logic              pullup_dis;
    logic              clk_sel;
    logic              edge_fall;
    logic              ps_to_wdt;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/twd_cfg_reg.sv
module twd_cfg_reg
  import twd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   cfg_q <= cfg_t'({CFG_W{1'b1}});
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  assert_cfg_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q == cfg_t'($past(wdata_i))));
endmodule

// File: rtl/twd_edge_sync.sv
module twd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

  assert_edge_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/twd_prescaler.sv
module twd_prescaler #(
  parameter int PS_W = 8,
  parameter int SH_W = $clog2(PS_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            in_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            out_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign mask[i] = (SH_W'(i) < shift_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (in_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign out_o = in_i && !clr_i && (&(cnt_q | ~mask));

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/twd_timer.sv
module twd_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         wrap;

  assign wrap = tick_i && !we_i && (&cnt_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (we_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_wrap_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && cnt_q == {W{1'b1}}) |=> (ovf_q && cnt_q == '0));
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/twd_watchdog.sv
module twd_watchdog #(
  parameter int LIMIT = 16,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic timeout_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          to_q;
  logic          expire;

  assign expire = tick_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (expire) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) to_q <= 1'b0;
    else         to_q <= expire;
  end

  assign timeout_o = to_q;

  assert_timeout_follows_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(tick_i && !clr_i));
  assert_clear_blocks_timeout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !timeout_o);
endmodule

// File: rtl/tmr_wdt_shared.sv
module tmr_wdt_shared
  import twd_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int PS_W      = 8,
  parameter int WDT_LIMIT = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             insn_tick_i,
  input  logic             ext_clk_i,
  input  logic             tmr_we_i,
  input  logic [TMR_W-1:0] tmr_wdata_i,
  input  logic             ovf_clr_i,
  input  logic             wdt_tick_i,
  input  logic             wdt_clr_i,
  output logic [TMR_W-1:0] tmr_count_o,
  output logic             tmr_ovf_o,
  output logic             wdt_timeout_o,
  output logic             ext_force_in_o,
  output logic             wake_dis_o,
  output logic             pullup_dis_o
);
  localparam int SH_W = $clog2(PS_W + 1);

  cfg_t            cfg;
  logic            ext_rise, ext_fall, ext_evt, src_evt;
  logic            ps_in, ps_out, ps_clr;
  logic [SH_W-1:0] shift;
  logic            tmr_tick, wdt_evt;

  twd_cfg_reg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg)
  );

  twd_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .async_i(ext_clk_i), .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign ext_evt = cfg.edge_fall ? ext_fall : ext_rise;
  assign src_evt = cfg.clk_sel ? ext_evt : insn_tick_i;

  assign shift  = cfg.ps_to_wdt ? SH_W'(cfg.rate) : SH_W'(cfg.rate) + 1'b1;
  assign ps_in  = cfg.ps_to_wdt ? wdt_tick_i : src_evt;
  assign ps_clr = wdt_clr_i || (tmr_we_i && !cfg.ps_to_wdt);

  twd_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i, .rst_ni, .clr_i(ps_clr), .in_i(ps_in), .shift_i(shift), .out_o(ps_out)
  );

  assign tmr_tick = cfg.ps_to_wdt ? src_evt : ps_out;
  assign wdt_evt  = cfg.ps_to_wdt ? ps_out : wdt_tick_i;

  twd_timer #(.W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .tick_i(tmr_tick), .we_i(tmr_we_i), .wdata_i(tmr_wdata_i),
    .ovf_clr_i, .cnt_o(tmr_count_o), .ovf_o(tmr_ovf_o)
  );

  twd_watchdog #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk_i, .rst_ni, .clr_i(wdt_clr_i), .tick_i(wdt_evt), .timeout_o(wdt_timeout_o)
  );

  assign ext_force_in_o = cfg.clk_sel;
  assign wake_dis_o     = cfg.wake_dis;
  assign pullup_dis_o   = cfg.pullup_dis;

  assert_cfg_ignored_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.clk_sel && !ext_evt && !tmr_we_i) |=> $stable(tmr_count_o));
endmodule

// File: tb/tmr_wdt_shared_tb_top.sv
module tmr_wdt_shared_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, insn_tick = 0, ext_clk = 0, tmr_we = 0;
  logic       ovf_clr = 0, wdt_tick = 0, wdt_clr = 0;
  logic [7:0] cfg_wdata = 0, tmr_wdata = 0;
  logic [7:0] tmr_count;
  logic       tmr_ovf, wdt_to, force_in, wake_dis, pull_dis;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  tmr_wdt_shared #(.WDT_LIMIT(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .insn_tick_i(insn_tick), .ext_clk_i(ext_clk), .tmr_we_i(tmr_we),
    .tmr_wdata_i(tmr_wdata), .ovf_clr_i(ovf_clr), .wdt_tick_i(wdt_tick),
    .wdt_clr_i(wdt_clr), .tmr_count_o(tmr_count), .tmr_ovf_o(tmr_ovf),
    .wdt_timeout_o(wdt_to), .ext_force_in_o(force_in), .wake_dis_o(wake_dis),
    .pullup_dis_o(pull_dis)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1; cyc(); cfg_we = 0;
  endtask

  task automatic write_tmr(input logic [7:0] v);
    tmr_wdata = v; tmr_we = 1; cyc(); tmr_we = 0;
  endtask

  task automatic insn(input int n);
    for (int i = 0; i < n; i++) begin
      insn_tick = 1; cyc(); insn_tick = 0;
    end
  endtask

  task automatic wdog(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick = 1; cyc(); wdt_tick = 0;
    end
  endtask

  task automatic clear_wdt();
    wdt_clr = 1; cyc(); wdt_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 count", tmr_count, 0);
    check("R1 ovf", tmr_ovf, 0);
    check("R1 timeout", wdt_to, 0);
    check("R1 force_in", force_in, 1);
    check("R1 wake_dis", wake_dis, 1);
    check("R1 pullup_dis", pull_dis, 1);
    insn(5);
    check("R1 insn ignored", tmr_count, 0);
  endtask

  task automatic t_internal();
    write_cfg(8'h08);
    check("R2 wake_dis bit7", wake_dis, 0);
    check("R3 force_in", force_in, 0);
    insn(5);
    check("R6 timer undivided", tmr_count, 5);
    ext_clk = 1; cyc(4); ext_clk = 0; cyc(4);
    check("R3 ext ignored", tmr_count, 5);
    write_cfg(8'h4F);
    check("R2 pullup_dis bit6", pull_dis, 1);
    insn(3);
    check("R6 rate7 timer still undivided", tmr_count, 8);
  endtask

  task automatic t_prescale_timer();
    write_cfg(8'h01);
    write_tmr(8'h00);
    insn(7);
    check("R5 /4 after 7", tmr_count, 1);
    insn(1);
    check("R5 /4 after 8", tmr_count, 2);
    write_cfg(8'h00);
    write_tmr(8'h00);
    insn(4);
    check("R5 /2 after 4", tmr_count, 2);
  endtask

  task automatic t_external();
    write_cfg(8'h28);
    write_tmr(8'h00);
    check("R3 force_in", force_in, 1);
    insn_tick = 1;
    ext_clk = 1; cyc(4);
    check("R4 rising counted", tmr_count, 1);
    ext_clk = 0; cyc(4);
    check("R4 falling not counted", tmr_count, 1);
    insn_tick = 0;
    write_cfg(8'h38);
    ext_clk = 1; cyc(4);
    check("R4 rising not counted", tmr_count, 1);
    ext_clk = 0; cyc(4);
    check("R4 falling counted", tmr_count, 2);
  endtask

  task automatic t_wrap();
    write_cfg(8'h08);
    write_tmr(8'hFE);
    insn(1);
    check("R7 no ovf at FF", tmr_ovf, 0);
    insn(1);
    check("R7 wrap count", tmr_count, 0);
    check("R7 ovf set", tmr_ovf, 1);
    insn(1);
    check("R7 ovf sticky", tmr_ovf, 1);
    ovf_clr = 1; cyc(); ovf_clr = 0;
    check("R7 ovf cleared", tmr_ovf, 0);
    write_tmr(8'hFF);
    insn_tick = 1; ovf_clr = 1; cyc(); insn_tick = 0; ovf_clr = 0;
    check("R7 set beats clear", tmr_ovf, 1);
    tmr_wdata = 8'h40; tmr_we = 1; insn_tick = 1; cyc();
    tmr_we = 0; insn_tick = 0;
    check("R10 write beats tick", tmr_count, 8'h40);
  endtask

  task automatic t_write_clears_ps();
    write_cfg(8'h01);
    write_tmr(8'h00);
    insn(3);
    write_tmr(8'h10);
    insn(3);
    check("R8 prescaler emptied", tmr_count, 8'h10);
    insn(1);
    check("R8 count after full period", tmr_count, 8'h11);
  endtask

  task automatic t_watchdog();
    write_cfg(8'h08);
    clear_wdt();
    wdog(3);
    check("R9 no early timeout", wdt_to, 0);
    wdog(1);
    check("R9 timeout /1", wdt_to, 1);
    cyc();
    check("R9 one cycle pulse", wdt_to, 0);
    write_cfg(8'h09);
    clear_wdt();
    wdog(7);
    check("R6 /2 not yet", wdt_to, 0);
    wdog(1);
    check("R6 /2 timeout", wdt_to, 1);
    clear_wdt();
    wdog(5); clear_wdt(); wdog(5);
    check("R9 clear restarts", wdt_to, 0);
    wdog(3);
    check("R9 timeout after clear", wdt_to, 1);
    clear_wdt();
    wdog(1);
    write_tmr(8'h00);
    wdog(7);
    check("R8 timer write keeps wdt prescaler", wdt_to, 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    t_reset();
    t_internal();
    t_prescale_timer();
    t_external();
    t_wrap();
    t_write_clears_ps();
    t_watchdog();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule